// File: doc/BRIEF.md
# Link-On Wake Signal Generator

This block drives the wake-up line that a serial-bus physical layer uses to rouse a link controller that has powered down. It inspects each received PHY packet, presented as two 32-bit quadlets with a one-cycle valid strobe. A packet that is a well-formed link-on request addressed to this node, arriving while the link power status input reports the link as down, starts a square wave on the wake output. The wave is derived from the core clock. Its divider follows the clock-select input, so the output stays near 6.144 MHz at either core rate.

The wave stops when the link reports itself powered, or when a bus reset event occurs. While idle the output is driven low. During hardware reset the output enable is deasserted so the external pad floats. The block also holds the node's 6-bit physical ID. The ID loads from strap inputs on hardware or soft reset, software may overwrite it, and the packet matcher compares against its current value.

Top module: `linkon_wake_gen`

## Requirements
- R1: While `rst_n` is low, `wake_oe` and `wake_out` are 0; at the first clock edge after `rst_n` rises, `wake_oe` becomes 1 and stays 1.
- R2: When no wave is active, `wake_out` is 0.
- R3: A packet with `pkt_valid`=1, `pkt_q0[31:30]`=2'b01, `pkt_q0[29:24]` equal to `phy_id`, and `pkt_q1` equal to `~pkt_q0`, sampled while `link_pwr_on`=0, starts the wave at the next clock edge, with `wake_out`=1 from that edge.
- R4: A packet with the wrong type bits, a different ID, or a second quadlet that is not the exact inverse of the first leaves `wake_out` at 0.
- R5: A matching packet sampled while `link_pwr_on`=1 is discarded, and no request remains pending after the link drops again.
- R6: The active wave has a half-period of 8 clocks when `clk_sel`=0 and 4 clocks when `clk_sel`=1. The first half-period is high and has full length.
- R7: `link_pwr_on`=1 at a clock edge makes `wake_out` 0 from that edge on.
- R8: `bus_reset`=1 at a clock edge makes `wake_out` 0 from that edge on. It takes precedence over a matching packet in the same cycle.
- R9: `phy_id` takes the value of `strap_id` on hardware reset and at any edge where `soft_rst`=1. A soft reset takes precedence over a software write in the same cycle.
- R10: With `id_wr_en`=1 and `soft_rst`=0, `phy_id` takes `id_wr_data` at the clock edge, and later packets are matched against the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset, reloads the physical ID from the straps |
| clk_sel | input | 1 | Core rate select: 0 is the fast clock, 1 is the half-rate clock |
| bus_reset | input | 1 | Bus reset event, forces the wave off |
| link_pwr_on | input | 1 | Link power status, 1 when the link controller is active |
| pkt_valid | input | 1 | Received packet strobe |
| pkt_q0 | input | 32 | First quadlet of the received packet |
| pkt_q1 | input | 32 | Second quadlet of the received packet |
| strap_id | input | 6 | Strap value for the physical ID |
| id_wr_en | input | 1 | Software write strobe for the physical ID |
| id_wr_data | input | 6 | Software write value |
| phy_id | output | 6 | Current physical ID |
| wake_out | output | 1 | Wake square wave to the pad |
| wake_oe | output | 1 | Pad output enable, 0 during hardware reset |

## Verification
The hardest case to reach is the no-pending-request rule. A correct link-on packet arrives while the link is up, and the evidence that it was dropped shows only later, after the link has gone down. The stimulus sends that packet and then releases the link power status. It watches the wake output for several full periods, and only after that sends a fresh packet to show that activation still works. The order of the bus reset and the ID write against a packet in the same cycle is checked the same way: conflicting strobes are driven together, and the outcome is read on the wake output and the ID output.

// File: rtl/linkon_pkg.sv
package linkon_pkg;
    localparam int QUAD_W = 32;
    localparam int NODE_ID_W = 6;
    localparam logic [1:0] LINKON_CODE = 2'b01;
endpackage

// File: rtl/lnk_phyid_reg.sv
module lnk_phyid_reg #(
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic [ID_W-1:0] strap_id,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_data,
    output logic [ID_W-1:0] id
);
    typedef struct packed {
        logic [ID_W-1:0] id;
    } id_state_t;

    id_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d.id = strap_id;
        end else if (wr_en) begin
            st_d.id = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.id <= strap_id;
        end else begin
            st_q <= st_d;
        end
    end

    assign id = st_q.id;

    a_r9_soft_load: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (id == $past(strap_id)));

    a_r10_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst) |=> (id == $past(wr_data)));
endmodule

// File: rtl/lnk_pkt_match.sv
module lnk_pkt_match #(
    parameter int QW   = 32,
    parameter int ID_W = 6
) (
    input  logic            pkt_valid,
    input  logic [QW-1:0]   q0,
    input  logic [QW-1:0]   q1,
    input  logic [ID_W-1:0] node_id,
    input  logic            link_up,
    output logic            hit
);
    import linkon_pkg::*;

    localparam int TYPE_HI = QW - 1;
    localparam int TYPE_LO = QW - 2;
    localparam int ID_HI   = QW - 3;
    localparam int ID_LO   = QW - 2 - ID_W;

    logic type_ok, id_ok, inv_ok;

    always_comb begin
        type_ok = (q0[TYPE_HI:TYPE_LO] == LINKON_CODE);
        id_ok   = (q0[ID_HI:ID_LO] == node_id);
        inv_ok  = (q1 == ~q0);
        hit     = pkt_valid && type_ok && id_ok && inv_ok && !link_up;
    end
endmodule

// File: rtl/lnk_wake_div.sv
module lnk_wake_div #(
    parameter int DIV_FAST = 16,
    parameter int DIV_SLOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sel,
    input  logic start,
    input  logic link_up,
    input  logic bus_reset,
    output logic wave,
    output logic active
);
    localparam int HALF_FAST = DIV_FAST / 2;
    localparam int HALF_SLOW = DIV_SLOW / 2;
    localparam int HALF_MAX  = (HALF_FAST > HALF_SLOW) ? HALF_FAST : HALF_SLOW;
    localparam int CNT_W     = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

    typedef struct packed {
        logic             active;
        logic             wave;
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = clk_sel ? CNT_W'(HALF_SLOW - 1) : CNT_W'(HALF_FAST - 1);
        st_d = st_q;
        if (bus_reset || link_up) begin
            st_d.active = 1'b0;
            st_d.wave   = 1'b0;
            st_d.cnt    = '0;
        end else if (start && !st_q.active) begin
            st_d.active = 1'b1;
            st_d.wave   = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt >= last_cnt) begin
                st_d.wave = ~st_q.wave;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave   = st_q.active & st_q.wave;
    assign active = st_q.active;

    a_r3_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> (st_q.wave && st_q.cnt == '0));

    a_r6_toggle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && $past(st_q.active) && (st_q.wave != $past(st_q.wave)))
            |-> ($past(st_q.cnt) == $past(last_cnt)));

    a_r7_stop_on_link: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> !wave);

    a_r8_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !active);
endmodule

// File: rtl/linkon_wake_gen.sv
module linkon_wake_gen
    import linkon_pkg::*;
#(
    parameter int DIV_FAST = 16,
    parameter int DIV_SLOW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 clk_sel,
    input  logic                 bus_reset,
    input  logic                 link_pwr_on,
    input  logic                 pkt_valid,
    input  logic [QUAD_W-1:0]    pkt_q0,
    input  logic [QUAD_W-1:0]    pkt_q1,
    input  logic [NODE_ID_W-1:0] strap_id,
    input  logic                 id_wr_en,
    input  logic [NODE_ID_W-1:0] id_wr_data,
    output logic [NODE_ID_W-1:0] phy_id,
    output logic                 wake_out,
    output logic                 wake_oe
);
    logic pkt_hit;
    logic wave_active;

    typedef struct packed {
        logic oe;
    } top_state_t;

    top_state_t st_d, st_q;

    lnk_phyid_reg #(.ID_W(NODE_ID_W)) id_reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .strap_id (strap_id),
        .wr_en    (id_wr_en),
        .wr_data  (id_wr_data),
        .id       (phy_id)
    );

    lnk_pkt_match #(.QW(QUAD_W), .ID_W(NODE_ID_W)) match_i (
        .pkt_valid (pkt_valid),
        .q0        (pkt_q0),
        .q1        (pkt_q1),
        .node_id   (phy_id),
        .link_up   (link_pwr_on),
        .hit       (pkt_hit)
    );

    lnk_wake_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel   (clk_sel),
        .start     (pkt_hit),
        .link_up   (link_pwr_on),
        .bus_reset (bus_reset),
        .wave      (wake_out),
        .active    (wave_active)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_oe = st_q.oe;

    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_float_in_reset: assert (!wake_oe && !wake_out);
        end
    end

    a_r1_oe_held: assert property (@(posedge clk) disable iff (!rst_n)
        wake_oe |=> wake_oe);

    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_active |-> !wake_out);

    a_r5_no_start_when_up: assert property (@(posedge clk) disable iff (!rst_n)
        (link_pwr_on && !wave_active) |=> !wave_active);
endmodule

// File: tb/linkon_wake_gen_tb_top.sv
module linkon_wake_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        clk_sel = 1'b0;
    logic        bus_reset = 1'b0;
    logic        link_pwr_on = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [31:0] pkt_q0 = '0;
    logic [31:0] pkt_q1 = '0;
    logic [5:0]  strap_id = 6'h2A;
    logic        id_wr_en = 1'b0;
    logic [5:0]  id_wr_data = '0;
    logic [5:0]  phy_id;
    logic        wake_out;
    logic        wake_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    linkon_wake_gen dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clk_sel(clk_sel),
        .bus_reset(bus_reset), .link_pwr_on(link_pwr_on), .pkt_valid(pkt_valid),
        .pkt_q0(pkt_q0), .pkt_q1(pkt_q1), .strap_id(strap_id),
        .id_wr_en(id_wr_en), .id_wr_data(id_wr_data), .phy_id(phy_id),
        .wake_out(wake_out), .wake_oe(wake_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk_q0(input logic [5:0] id, input logic [1:0] code);
        return {code, id, 24'h5C3A71};
    endfunction

    // Drive one packet for a single cycle, return at the negedge after capture.
    task automatic send_pkt(input logic [31:0] q0, input logic [31:0] q1);
        pkt_valid = 1'b1;
        pkt_q0 = q0;
        pkt_q1 = q1;
        tick();
        pkt_valid = 1'b0;
    endtask

    task automatic expect_low(input int cycles, input string req);
        bit bad = 0;
        for (int k = 0; k < cycles; k++) begin
            if (wake_out !== 1'b0) bad = 1;
            tick();
        end
        check(!bad, req, bad, 0);
    endtask

    task automatic stop_wave();
        bus_reset = 1'b1;
        tick();
        bus_reset = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(wake_oe === 1'b0, "R1 oe in reset", wake_oe, 0);
        check(wake_out === 1'b0, "R1 out in reset", wake_out, 0);
        check(phy_id === 6'h2A, "R9 strap load", phy_id, 6'h2A);
        rst_n = 1'b1;
        tick();
        check(wake_oe === 1'b1, "R1 oe after reset", wake_oe, 1);
        expect_low(6, "R2 idle low");
    endtask

    task automatic t_wave(input logic sel, input int half);
        bit bad = 0;
        clk_sel = sel;
        link_pwr_on = 1'b0;
        send_pkt(mk_q0(phy_id, 2'b01), ~mk_q0(phy_id, 2'b01));
        check(wake_out === 1'b1, "R3 start", wake_out, 1);
        for (int k = 0; k < 4 * half; k++) begin
            if (wake_out !== (((k / half) % 2) == 0)) begin
                bad = 1;
                $display("FAIL R6 sel=%0d k=%0d: actual %0d expected %0d",
                         sel, k, wake_out, ((k / half) % 2) == 0);
            end
            tick();
        end
        n_checks++;
        if (bad) n_fail++;
        link_pwr_on = 1'b1;
        tick();
        check(wake_out === 1'b0, "R7 link up stops", wake_out, 0);
        link_pwr_on = 1'b0;
        expect_low(2 * half, "R7 stays low");
    endtask

    task automatic t_bad_pkts();
        logic [31:0] g;
        g = mk_q0(phy_id, 2'b01);
        send_pkt(mk_q0(phy_id, 2'b11), ~mk_q0(phy_id, 2'b11));
        expect_low(20, "R4 bad type");
        send_pkt(mk_q0(phy_id ^ 6'h01, 2'b01), ~mk_q0(phy_id ^ 6'h01, 2'b01));
        expect_low(20, "R4 other id");
        send_pkt(g, ~g ^ 32'h0000_0100);
        expect_low(20, "R4 bad inverse");
    endtask

    task automatic t_link_active_pkt();
        logic [31:0] g;
        g = mk_q0(phy_id, 2'b01);
        link_pwr_on = 1'b1;
        send_pkt(g, ~g);
        expect_low(3, "R5 while up");
        link_pwr_on = 1'b0;
        expect_low(20, "R5 no pending");
        send_pkt(g, ~g);
        check(wake_out === 1'b1, "R5 later start", wake_out, 1);
        stop_wave();
    endtask

    task automatic t_bus_reset();
        logic [31:0] g;
        g = mk_q0(phy_id, 2'b01);
        clk_sel = 1'b0;
        send_pkt(g, ~g);
        tick();
        tick();
        check(wake_out === 1'b1, "R8 running", wake_out, 1);
        stop_wave();
        check(wake_out === 1'b0, "R8 forced low", wake_out, 0);
        expect_low(20, "R8 stays low");
        bus_reset = 1'b1;
        send_pkt(g, ~g);
        bus_reset = 1'b0;
        expect_low(20, "R8 priority over packet");
    endtask

    task automatic t_id();
        logic [5:0] old_id;
        old_id = phy_id;
        id_wr_en = 1'b1;
        id_wr_data = 6'h15;
        tick();
        id_wr_en = 1'b0;
        check(phy_id === 6'h15, "R10 write", phy_id, 6'h15);
        send_pkt(mk_q0(old_id, 2'b01), ~mk_q0(old_id, 2'b01));
        expect_low(10, "R10 old id ignored");
        send_pkt(mk_q0(6'h15, 2'b01), ~mk_q0(6'h15, 2'b01));
        check(wake_out === 1'b1, "R10 new id match", wake_out, 1);
        stop_wave();
        strap_id = 6'h0C;
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        check(phy_id === 6'h0C, "R9 soft reload", phy_id, 6'h0C);
        soft_rst = 1'b1;
        id_wr_en = 1'b1;
        id_wr_data = 6'h3F;
        strap_id = 6'h21;
        tick();
        soft_rst = 1'b0;
        id_wr_en = 1'b0;
        check(phy_id === 6'h21, "R9 soft over write", phy_id, 6'h21);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_wave(1'b0, 8);
        t_wave(1'b1, 4);
        t_bad_pkts();
        t_link_active_pkt();
        t_bus_reset();
        t_id();
        finish_run();
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule